// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a stuck target holds low. Software can read the live levels of both bus lines at any time through a line-monitor register. When SDA is found low on an idle bus, software programs a clock count into a cycle register and sets a request bit in the control register. The block then drives that many SCL clock pulses with SDA released, so the target can finish shifting out whatever byte it was stuck in.

After the last pulse the block looks at SDA. If the target has let go, the block closes the sequence with a STOP condition. If SDA is still low, the block leaves the bus alone. Software can run one full burst of up to nine pulses, or it can request single pulses and check SDA between them. A glitch filter cleans the SDA input, and a configuration bit can bypass it. The block speaks a simple single-cycle register port and open-drain style line enables (an enable of 1 pulls the line low).

Register map (word addresses): control at 0, cycle at 1, line monitor at 2.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset all three registers read 0, except the monitor, which reads 3 with both lines high. Neither line enable is asserted and `busy_o` is low.
- R2: The monitor register returns the filtered SDA level in bit 0 and the SCL level in bit 1, where 0 means the line is low. A change on a line shows up within SYNC_STAGES+FILT_LEN cycles.
- R3: The cycle register holds the pulse count in bits 3:0 and the SDA filter bypass in bit 7. Reading it returns exactly those fields, and all other bits read 0.
- R4: Writing 1 to control bit 11 while idle, with a non-zero count, starts the sequence. It produces exactly as many SCL pulses as the count, each held low for HALF_CYC cycles and then released for HALF_CYC cycles. A count of 1 per request can be repeated.
- R5: SDA stays released for every recovery pulse. Whenever SCL starts being pulled low, SDA is not being pulled low.
- R6: The request bit reads 1 and `busy_o` stays high from the start of the sequence to its end. Both clear by themselves afterwards, and neither line is driven while idle.
- R7: If SDA reads high after the final pulse, the block issues a STOP. SDA is pulled low only while SCL is low, then SCL is released, then SDA is released. If SDA is still low, no STOP is issued and SDA is never driven.
- R8: A request with a programmed count of 0 produces no pulse, and the request bit never reads 1.
- R9: Writes made during a sequence, whether to the request bit or to the cycle register, do not change the number of pulses in that sequence. The new cycle value is still stored.
- R10: With the bypass bit clear, an SDA glitch shorter than FILT_LEN cycles does not reach the monitor. With the bypass bit set, it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Recovery sequence in progress |

## Verification
The bound checker watches the line-enable ordering on every cycle: no SDA pull-down without SCL held low, and SDA released whenever an SCL pull-down begins. It also checks that both lines are quiet while idle, that a zero-count request never raises busy, and that the number of pulses in each sequence matches the count latched when it started. The pulse widths, the choice between ending with a STOP and ending without one, the field layout of the registers, the monitor latency, and the glitch-filter bypass all depend on chosen stimulus. The directed scenarios of the bench cover these.

// File: rtl/i2c_clr_pkg.sv
package i2c_clr_pkg;
  localparam int DATA_W      = 32;
  localparam int CNT_W       = 4;
  localparam int REQ_BIT     = 11;
  localparam int BYP_BIT     = 7;
  localparam int MON_SDA_BIT = 0;
  localparam int MON_SCL_BIT = 1;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CYC  = 2'd1;
  localparam logic [1:0] ADDR_MON  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STP_PRE,
    ST_STP_SDA,
    ST_STP_REL
  } clr_state_e;
endpackage

// File: rtl/i2c_clr_timer.sv
module i2c_clr_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [TW-1:0] t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           t_q <= '0;
    else if (load_i)       t_q <= TW'(HALF_CYC - 1);
    else if (t_q != '0)    t_q <= t_q - 1'b1;
  end

  assign done_o = (t_q == '0);
endmodule

// File: rtl/i2c_clr_filt.sv
module i2c_clr_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic bypass_i,
  output logic lvl_o
);
  logic synced;
  logic stable;

  // synchronizer, idle-high reset
  if (SYNC_STAGES <= 1) begin : g_sync1
    logic s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= 1'b1;
      else         s_q <= line_i;
    end
    assign synced = s_q;
  end else begin : g_syncn
    logic [SYNC_STAGES-1:0] s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= '1;
      else         s_q <= {s_q[SYNC_STAGES-2:0], line_i};
    end
    assign synced = s_q[SYNC_STAGES-1];
  end

  // level must persist FILT_LEN cycles before it is accepted
  if (FILT_LEN <= 1) begin : g_nofilt
    assign stable = synced;
  end else begin : g_filt
    localparam int CW = $clog2(FILT_LEN);
    logic [CW-1:0] cnt_q;
    logic          stable_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q    <= '0;
        stable_q <= 1'b1;
      end else if (synced != stable_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          stable_q <= synced;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
    assign stable = stable_q;
  end

  assign lvl_o = bypass_i ? synced : stable;
endmodule

// File: rtl/i2c_clr_seq.sv
module i2c_clr_seq
  import i2c_clr_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             sda_lvl_i,
  output logic             busy_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  clr_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             load, done;

  i2c_clr_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .done_o (done)
  );

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i && count_i != '0) begin
        state_d = ST_LOW;
        left_d  = count_i;
        load    = 1'b1;
      end
      ST_LOW: if (done) begin
        state_d = ST_HIGH;
        load    = 1'b1;
      end
      ST_HIGH: if (done) begin
        if (left_q == CNT_W'(1)) begin
          // target let go of SDA: close with STOP
          if (sda_lvl_i) begin
            state_d = ST_STP_PRE;
            load    = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          left_d  = left_q - 1'b1;
          state_d = ST_LOW;
          load    = 1'b1;
        end
      end
      ST_STP_PRE: if (done) begin
        state_d = ST_STP_SDA;
        load    = 1'b1;
      end
      ST_STP_SDA: if (done) begin
        state_d = ST_STP_REL;
        load    = 1'b1;
      end
      ST_STP_REL: if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign scl_oe_o = (state_q == ST_LOW) || (state_q == ST_STP_PRE) || (state_q == ST_STP_SDA);
  assign sda_oe_o = (state_q == ST_STP_SDA) || (state_q == ST_STP_REL);
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_clr_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o
);
  localparam int NLINES = 2;

  logic [CNT_W-1:0]  cyc_cnt_q;
  logic              byp_q;
  logic              start;
  logic [NLINES-1:0] line_raw, line_byp, line_lvl;
  logic              wdata_unused;

  assign wdata_unused = ^{reg_wdata_i[DATA_W-1:REQ_BIT+1], reg_wdata_i[REQ_BIT-1:BYP_BIT+1],
                          reg_wdata_i[BYP_BIT-1:CNT_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_cnt_q <= '0;
      byp_q     <= 1'b0;
    end else if (reg_we_i && reg_addr_i == ADDR_CYC) begin
      cyc_cnt_q <= reg_wdata_i[CNT_W-1:0];
      byp_q     <= reg_wdata_i[BYP_BIT];
    end
  end

  // zero count or busy: request is dropped
  assign start = reg_we_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[REQ_BIT]
                 && !busy_o && (cyc_cnt_q != '0);

  assign line_raw = {scl_i, sda_i};
  assign line_byp = {1'b0, byp_q};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_clr_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (line_raw[g]),
      .bypass_i (line_byp[g]),
      .lvl_o    (line_lvl[g])
    );
  end

  i2c_clr_seq #(.HALF_CYC(HALF_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .count_i   (cyc_cnt_q),
    .sda_lvl_i (line_lvl[0]),
    .busy_o    (busy_o),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o[REQ_BIT] = busy_o;
      ADDR_CYC: begin
        reg_rdata_o[CNT_W-1:0] = cyc_cnt_q;
        reg_rdata_o[BYP_BIT]   = byp_q;
      end
      ADDR_MON: begin
        reg_rdata_o[MON_SDA_BIT] = line_lvl[0];
        reg_rdata_o[MON_SCL_BIT] = line_lvl[1];
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk
  import i2c_clr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_ctrl_i,
  input logic             req_bit_i,
  input logic [CNT_W-1:0] cyc_cnt_i,
  input logic             busy_i,
  input logic             scl_oe_i,
  input logic             sda_oe_i
);
  logic             req_go;
  logic             scl_q;
  logic [CNT_W:0]   pcnt_q;
  logic [CNT_W-1:0] lat_q;

  assign req_go = wr_ctrl_i && req_bit_i && !busy_i && (cyc_cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b0;
      pcnt_q <= '0;
      lat_q  <= '0;
    end else begin
      scl_q <= scl_oe_i;
      if (req_go) begin
        pcnt_q <= '0;
        lat_q  <= cyc_cnt_i;
      end else if (scl_q && !scl_oe_i && !sda_oe_i) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!scl_oe_i && !sda_oe_i)); // R6

  AST_SDA_FREE_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_i) |-> !sda_oe_i); // R5

  AST_NO_FALSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> scl_oe_i); // R7

  AST_ZERO_COUNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && req_bit_i && !busy_i && cyc_cnt_i == '0) |=> !busy_i); // R8

  AST_PULSE_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (pcnt_q == {1'b0, lat_q})); // R4
endmodule

bind i2c_bus_clear i2c_bus_clear_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_ctrl_i (reg_we_i && (reg_addr_i == i2c_clr_pkg::ADDR_CTRL)),
  .req_bit_i (reg_wdata_i[i2c_clr_pkg::REQ_BIT]),
  .cyc_cnt_i (cyc_cnt_q),
  .busy_i    (busy_o),
  .scl_oe_i  (scl_oe_o),
  .sda_oe_i  (sda_oe_o)
);

// File: tb/test_i2c_bus_clear.sv
module test_i2c_bus_clear;
  localparam int HALF = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_CYC = 2'd1, A_MON = 2'd2;
  localparam logic [31:0] REQ = 32'h800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic scl_oe, sda_oe, busy;
  logic tgt_sda_low = 1'b0, tgt_scl_low = 1'b0;
  logic scl_line, sda_line;

  int checks = 0, errors = 0;
  int pulses = 0, width_err = 0, sda_drv = 0, stop_bad = 0, busy_bad = 0, low_run = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;

  assign scl_line = ~(scl_oe | tgt_scl_low);
  assign sda_line = ~(sda_oe | tgt_sda_low);

  always #5 clk = ~clk;

  i2c_bus_clear #(.HALF_CYC(HALF)) i_i2c_bus_clear (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  // line monitor
  always @(negedge clk) begin
    if (prev_scl && !scl_oe && !sda_oe) begin
      pulses++;
      if (low_run != HALF) width_err++;
    end
    low_run = scl_oe ? low_run + 1 : 0;
    if (!prev_sda && sda_oe) sda_drv++;
    if (prev_sda && !sda_oe && scl_oe) stop_bad++;
    if (scl_oe && !busy) busy_bad++;
    prev_scl = scl_oe;
    prev_sda = sda_oe;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    step(); we = 1'b1; addr = a; wdata = d;
    step(); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    step(); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) step();
  endtask

  task automatic settle();
    for (int i = 0; i < 8; i++) step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_CYC, d);  chk("R1 cyc", d, 0);
    rd(A_MON, d);  chk("R1 mon", d, 3);
    chk("R1 lines", {busy, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(A_CYC, 32'h8F); rd(A_CYC, d); chk("R3 fields", d, 32'h8F);
    wr(A_CYC, 32'hFFFF_FF75); rd(A_CYC, d); chk("R3 mask", d, 32'h05);
    wr(A_CYC, 0);
  endtask

  task automatic t_monitor();
    logic [31:0] d;
    tgt_sda_low = 1; tgt_scl_low = 1; settle();
    rd(A_MON, d); chk("R2 both low", d, 0);
    tgt_scl_low = 0; settle();
    rd(A_MON, d); chk("R2 sda low", d, 2);
    tgt_sda_low = 0; settle();
    rd(A_MON, d); chk("R2 both high", d, 3);
  endtask

  task automatic t_burst_stuck();
    logic [31:0] d;
    int p0, s0, w0;
    tgt_sda_low = 1; settle();
    wr(A_CYC, 9);
    p0 = pulses; s0 = sda_drv; w0 = width_err;
    wr(A_CTRL, REQ);
    chk("R6 busy", busy, 1);
    rd(A_CTRL, d); chk("R6 req reads 1", d, REQ);
    wait_idle();
    chk("R4 nine pulses", pulses - p0, 9);
    chk("R4 width", width_err - w0, 0);
    chk("R7 no stop when low", sda_drv - s0, 0);
    rd(A_CTRL, d); chk("R6 self clear", d, 0);
    chk("R6 busy whole seq", busy_bad, 0);
    tgt_sda_low = 0; settle();
  endtask

  task automatic t_single_steps();
    int p0, s0;
    wr(A_CYC, 1);
    for (int k = 0; k < 3; k++) begin
      tgt_sda_low = (k < 2); settle();
      p0 = pulses; s0 = sda_drv;
      wr(A_CTRL, REQ);
      wait_idle(); step();
      chk("R4 single pulse", pulses - p0, 1);
      chk("R7 stop only when released", sda_drv - s0, (k < 2) ? 0 : 1);
    end
    chk("R7 stop order", stop_bad, 0);
    chk("R6 lines free", {scl_oe, sda_oe}, 0);
    tgt_sda_low = 0;
  endtask

  task automatic t_zero();
    logic [31:0] d;
    int p0;
    wr(A_CYC, 0);
    p0 = pulses;
    wr(A_CTRL, REQ);
    chk("R8 no busy", busy, 0);
    rd(A_CTRL, d); chk("R8 req 0", d, 0);
    for (int i = 0; i < 20; i++) step();
    chk("R8 no pulse", pulses - p0, 0);
  endtask

  task automatic t_busy_writes();
    logic [31:0] d;
    int p0;
    tgt_sda_low = 1; settle();
    wr(A_CYC, 3);
    p0 = pulses;
    wr(A_CTRL, REQ);
    wr(A_CYC, 9);
    wr(A_CTRL, REQ);
    wait_idle();
    chk("R9 latched count", pulses - p0, 3);
    rd(A_CYC, d); chk("R9 cyc stored", d, 9);
    tgt_sda_low = 0; settle();
  endtask

  task automatic t_glitch(logic byp, logic exp_seen);
    logic [31:0] d;
    logic seen;
    wr(A_CYC, byp ? 32'h80 : 32'h0);
    settle();
    seen = 1'b0;
    step(); tgt_sda_low = 1;
    step(); tgt_sda_low = 0;
    addr = A_MON;
    for (int i = 0; i < 8; i++) begin
      step(); #1; d = rdata;
      if (!d[0]) seen = 1'b1;
    end
    chk(byp ? "R10 bypass shows glitch" : "R10 filter hides glitch", seen, exp_seen);
    wr(A_CYC, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_fields();
    t_monitor();
    t_burst_stuck();
    t_single_steps();
    t_zero();
    t_busy_writes();
    t_glitch(1'b0, 1'b0);
    t_glitch(1'b1, 1'b1);
    summary();
  end
endmodule